// File: doc/BRIEF.md
# Load/Store Alignment Checker and Load Data Rotator

This unit sits between the address path of a load/store pipeline and the memory read data. Each request gives it the low bits of the access address, the access size, the direction (load or store), and three control bits: strict alignment checking, unaligned-access permission, and the memory byte order. It decides whether the access raises an alignment fault, proceeds normally, has its data rotated in the legacy way, or goes to a separate path that splits unaligned accesses. For loads it also takes the aligned memory word that was read and returns the result laid out in the right byte order and zero-extended to the data width.

The three modes follow a fixed priority. Strict checking comes first and faults any misaligned access. If strict checking is off and unaligned support is also off, a misaligned load returns the aligned word rotated. If strict checking is off and unaligned support is on, a misaligned access is flagged as a pass-through request, because splitting it into bus transactions is done elsewhere. The response is registered and appears one cycle after the request.

Top module: `ldst_align_unit`

## Requirements
- R1: Size is coded as 0 = byte, 1 = halfword, 2 = word (3 is treated as word). An access is misaligned when it is a halfword with address bit 0 set, or a word with address bits [1:0] nonzero. Byte accesses are never misaligned and never fault.
- R2: With strict checking set, a misaligned load or store asserts `rsp_fault`. An aligned access never faults.
- R3: Strict checking takes priority over unaligned permission. When both are set, a misaligned access faults and `rsp_passthru` stays low.
- R4: With strict checking clear and unaligned permission clear, a misaligned load returns the aligned word rotated right by 8 times address bits [1:0], and the access size then selects the result.
- R5: With strict checking clear and unaligned permission set, a misaligned load or store asserts `rsp_passthru`, does not fault, and returns zero data.
- R6: In little-endian mode (`cfg_big_end`=0), byte address k within the word is bits [8k+7:8k] of `mem_rdata`. The byte at the lowest address is the least significant byte of the result, and the result is zero-extended.
- R7: In big-endian word-invariant mode (`cfg_big_end`=1), byte address 0 is bits [31:24] of `mem_rdata`, and byte address k is bits [31-8k:24-8k]. The byte at the lowest address is the most significant byte of a halfword or word result. An aligned word comes back unchanged.
- R8: Stores and faulting accesses return `rsp_data` = 0.
- R9: `rsp_valid` follows `req_valid` by exactly one clock. When no request was given in the previous cycle, `rsp_fault`, `rsp_passthru` and `rsp_data` are all 0.
- R10: While reset is asserted (`rst_n` low), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Access byte address |
| req_size | input | 2 | Access size code |
| req_store | input | 1 | 1 = store, 0 = load |
| cfg_strict | input | 1 | Strict alignment checking enable |
| cfg_unal_en | input | 1 | Unaligned access permission |
| cfg_big_end | input | 1 | 1 = big-endian word-invariant memory |
| mem_rdata | input | DATA_W | Aligned memory word for the request |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Alignment fault |
| rsp_passthru | output | 1 | Misaligned access handed to the split path |
| rsp_data | output | DATA_W | Formatted load data |

## Verification
The mode decode is driven with random address offsets, sizes, directions and all eight combinations of the control bits. This shows that fault, rotate and pass-through are kept apart, and that the strict bit overrides the unaligned bit. The data path is checked with random memory words in both byte orders, against a model that reads individual byte addresses rather than rotating. A rotation in the wrong direction, a lane swap, or a half-swapped halfword each gives a different value. Directed cases cover every offset for halfwords and words, a byte access with strict checking on, stores, and an idle cycle after a response.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } acc_size_e;
endpackage

// File: rtl/align_check.sv
module align_check
  import align_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] addr_lo,
  input  logic [1:0]       size,
  input  logic             strict,
  input  logic             unal_en,
  input  logic             is_store,
  output logic             misaligned,
  output logic             fault,
  output logic             passthru,
  output logic             rotate_ld
);
  // Low-address mask that has to be zero for a naturally aligned access.
  function automatic logic [OFS_W-1:0] width_mask(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: width_mask = '0;
      SZ_HALF: width_mask = OFS_W'(1);
      default: width_mask = OFS_W'(3);
    endcase
  endfunction

  always_comb begin
    misaligned = |(addr_lo & width_mask(size));
    fault      = misaligned & strict;
    passthru   = misaligned & ~strict & unal_en;
    rotate_ld  = misaligned & ~strict & ~unal_en & ~is_store;
  end

  // R3: the three modes never overlap
  always_comb begin
    a_r3_modes_exclusive: assert ($countones({fault, passthru, rotate_ld}) <= 1)
      else $error("alignment modes overlap");
  end
endmodule

// File: rtl/load_rotator.sv
module load_rotator #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              big_end,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DATA_W-1:0] norm,
  output logic [DATA_W-1:0] rotated
);
  function automatic logic [DATA_W-1:0] swap_lanes(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = w[8*(LANES-1-i) +: 8];
    return r;
  endfunction

  // Rotate right by whole lanes: result lane i takes source lane (i+k) mod LANES.
  function automatic logic [DATA_W-1:0] ror_lanes(input logic [DATA_W-1:0] w,
                                                   input logic [OFS_W-1:0] k);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = w[8*((i + int'(k)) % LANES) +: 8];
    return r;
  endfunction

  // Place byte address k in lane k whatever the memory byte order.
  assign norm    = big_end ? swap_lanes(raw) : raw;
  assign rotated = ror_lanes(norm, ofs);
endmodule

// File: rtl/load_formatter.sv
module load_formatter
  import align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rotated,
  input  logic [1:0]        size,
  input  logic              big_end,
  output logic [DATA_W-1:0] result
);
  localparam int LANES = DATA_W / 8;

  function automatic logic [DATA_W-1:0] swap_lanes(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = w[8*(LANES-1-i) +: 8];
    return r;
  endfunction

  always_comb begin
    result = '0;
    case (acc_size_e'(size))
      SZ_BYTE: result[7:0]  = rotated[7:0];
      SZ_HALF: result[15:0] = big_end ? {rotated[7:0], rotated[15:8]} : rotated[15:0];
      default: result       = big_end ? swap_lanes(rotated) : rotated;
    endcase
  end
endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_store,
  input  logic              cfg_strict,
  input  logic              cfg_unal_en,
  input  logic              cfg_big_end,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_passthru,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [OFS_W-1:0]  ofs;
  logic              chk_misal, chk_fault, chk_pass, chk_rot;
  logic [DATA_W-1:0] norm_word, rot_word, fmt_word;
  logic              data_en;

  assign ofs = req_addr[OFS_W-1:0];

  align_check #(.OFS_W(OFS_W)) u_check (
    .addr_lo   (ofs),
    .size      (req_size),
    .strict    (cfg_strict),
    .unal_en   (cfg_unal_en),
    .is_store  (req_store),
    .misaligned(chk_misal),
    .fault     (chk_fault),
    .passthru  (chk_pass),
    .rotate_ld (chk_rot)
  );

  load_rotator #(.DATA_W(DATA_W)) u_rot (
    .raw    (mem_rdata),
    .big_end(cfg_big_end),
    .ofs    (ofs),
    .norm   (norm_word),
    .rotated(rot_word)
  );

  load_formatter #(.DATA_W(DATA_W)) u_fmt (
    .rotated(rot_word),
    .size   (req_size),
    .big_end(cfg_big_end),
    .result (fmt_word)
  );

  // Load data is returned only for loads that neither fault nor go to the split path.
  assign data_en = req_valid & ~req_store & ~chk_fault & ~chk_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_passthru <= 1'b0;
      rsp_data     <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_fault    <= req_valid & chk_fault;
      rsp_passthru <= req_valid & chk_pass;
      rsp_data     <= data_en ? fmt_word : '0;
    end
  end

  a_r1_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |=> !rsp_fault);

  a_r3_strict_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_strict && chk_misal) |=> (rsp_fault && !rsp_passthru));

  a_r8_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_data == '0);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && !rsp_passthru && rsp_data == '0));

  a_r4_rotate_not_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && chk_rot) |=> (!rsp_fault && !rsp_passthru));
endmodule

// File: tb/ldst_align_unit_tb.sv
module ldst_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_store = 1'b0;
  logic        cfg_strict = 1'b0;
  logic        cfg_unal_en = 1'b0;
  logic        cfg_big_end = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_passthru;
  logic [31:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  ldst_align_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .cfg_strict(cfg_strict),
    .cfg_unal_en(cfg_unal_en), .cfg_big_end(cfg_big_end), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_passthru(rsp_passthru),
    .rsp_data(rsp_data)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit misal(input logic [1:0] a, input logic [1:0] sz);
    return (int'(a) % nbytes(sz)) != 0;
  endfunction

  // Byte stored at byte address k of the word.
  function automatic logic [7:0] mem_byte(input logic [31:0] w, input int k, input bit be);
    return be ? w[8*(3-k) +: 8] : w[8*k +: 8];
  endfunction

  // Expected load value: byte n of the access comes from address (a+n) mod 4.
  function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] a,
                                           input logic [1:0] sz, input bit be);
    logic [31:0] r = '0;
    int n = nbytes(sz);
    for (int i = 0; i < n; i++) begin
      int pos = be ? (n - 1 - i) : i;
      r[8*pos +: 8] = mem_byte(w, (int'(a) + i) % 4, be);
    end
    return r;
  endfunction

  task automatic run_req(input logic [1:0] a, input logic [1:0] sz, input bit st,
                         input bit s, input bit u, input bit be, input logic [31:0] w);
    bit mis, e_fault, e_pass;
    logic [31:0] e_data;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {$urandom, a}; req_size = sz; req_store = st;
    cfg_strict = s; cfg_unal_en = u; cfg_big_end = be; mem_rdata = w;
    mis = misal(a, sz);
    e_fault = mis && s;
    e_pass  = mis && !s && u;
    e_data  = (st || e_fault || e_pass) ? 32'h0 : exp_load(w, a, sz, be);
    if (sz == 2'd0 && s)       tag = "R1";
    else if (mis && s && u)    tag = "R3";
    else if (mis && s)         tag = "R2";
    else if (e_pass)           tag = "R5";
    else if (st)               tag = "R8";
    else if (mis)              tag = "R4";
    else if (be)               tag = "R7";
    else                       tag = "R6";
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(tag, "rsp_fault", {31'b0, rsp_fault}, {31'b0, e_fault});
    check(tag, "rsp_passthru", {31'b0, rsp_passthru}, {31'b0, e_pass});
    check(tag, "rsp_data", rsp_data, e_data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R10", "rsp_fault", {31'b0, rsp_fault}, 32'd0);
    check("R10", "rsp_passthru", {31'b0, rsp_passthru}, 32'd0);
    check("R10", "rsp_data", rsp_data, 32'd0);
    rst_n = 1'b1;

    // Directed corners
    run_req(2'd1, 2'd2, 0, 0, 0, 0, 32'h44332211); // R4 legacy rotate, LE
    run_req(2'd3, 2'd2, 0, 0, 0, 1, 32'h11223344); // R4 rotate, BE
    run_req(2'd3, 2'd0, 0, 1, 0, 0, 32'hA1B2C3D4); // R1 byte with strict
    run_req(2'd2, 2'd2, 1, 1, 1, 0, 32'h0);        // R3 both set, store
    run_req(2'd1, 2'd1, 0, 0, 1, 1, 32'hDEADBEEF); // R5 pass-through
    run_req(2'd0, 2'd2, 0, 0, 0, 1, 32'hCAFEF00D); // R7 aligned BE word unchanged
    run_req(2'd2, 2'd1, 0, 1, 0, 1, 32'h01020304); // R7 aligned BE halfword
    run_req(2'd2, 2'd1, 0, 1, 0, 0, 32'h01020304); // R6 aligned LE halfword
    run_req(2'd1, 2'd1, 1, 1, 0, 0, 32'h0);        // R2 store faults
    for (int a = 0; a < 4; a++)
      for (int sz = 0; sz < 4; sz++)
        run_req(2'(a), 2'(sz), 0, 0, 0, 0, 32'h8877_6655);

    // R9: an idle cycle gives a quiet response
    @(negedge clk);
    check("R9", "idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R9", "idle rsp_data", rsp_data, 32'd0);

    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++)
      run_req(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), $urandom);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule